// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a single-clock SRAM for a bus on which reads and writes can follow each other in every cycle. Every control, address and write-data input is registered on the rising clock edge. Each access has a fixed two-stage pipeline. A read command returns its word from an output register two enabled edges after the command. A write command takes its data two enabled edges after the command. Because the two latencies match, the data bus never has to idle when the traffic switches direction.

An access starts with a fresh address. It may then run on as a burst of up to four beats. A 2-bit counter rewrites the two low address bits, in either incrementing or XOR order. A write can update any subset of the four byte lanes. A hold input freezes the whole block for as many cycles as it stays high. Three select inputs must all agree before a cycle counts as an access. The depth is a parameter so that the model stays small in simulation. The data word is 32 bits wide.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rvalid` is 0 after that edge, and `bus_drive` is therefore 0 as well.
- R2: A cycle is an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is an idle cycle. An idle cycle writes nothing, and two enabled edges later it shows `rvalid`=0.
- R3: A new read is a selected cycle with `burst_cont`=0 and `is_read`=1. After the second enabled edge that follows its command edge, it shows `rvalid`=1 and the word in `rdata`. On read-less slots `rvalid` is 0.
- R4: A new write is a selected cycle with `burst_cont`=0 and `is_read`=0. It takes `wdata` at the second enabled edge after its command edge. For each byte lane i with `lane_en_n[i]`=0, it updates bits [8i+7:8i], using the `lane_en_n` value sampled together with the command. Lanes with `lane_en_n[i]`=1 keep their old contents.
- R5: Reads and writes may alternate on consecutive cycles with no idle cycle between them. A read issued right after a write to the same address returns the written data.
- R6: A selected cycle with `burst_cont`=1 that follows an active access continues it. The continuation keeps the read/write type of the access and ignores `is_read`. With `ilv_order`=0, the low two address bits are the start value plus the beat count, modulo 4. The upper bits do not change.
- R7: With `ilv_order`=1, the low two address bits of a burst beat are the start value XOR the beat count.
- R8: At a clock edge where `hold`=1, nothing changes: the output register, the burst state, the pipeline and the memory. Latencies count only edges with `hold`=0, and this includes the sampling of write data.
- R9: `bus_drive` equals `rvalid` when `out_en_n`=0 and is 0 when `out_en_n`=1. It follows `out_en_n` without waiting for a clock edge.
- R10: A selected cycle with `burst_cont`=1 that follows an idle cycle, or follows reset, is treated as an idle cycle.
- R11: The beat counter wraps after four beats, so a fifth beat addresses the start address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | 1 freezes the block at this edge |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| burst_cont | input | 1 | 0 starts an access, 1 continues a burst |
| is_read | input | 1 | 1 read, 0 write (new access only) |
| ilv_order | input | 1 | 0 incrementing, 1 XOR burst order |
| addr | input | AW | Word address |
| lane_en_n | input | 4 | Per-byte write enables, active low |
| wdata | input | 32 | Write data, taken two enabled edges after its command |
| out_en_n | input | 1 | Output driver enable, active low, asynchronous |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | rdata holds a read result this cycle |
| bus_drive | output | 1 | The driver would own the shared bus |

## Verification
Most internal faults surface on `rdata` or `rvalid` within the two enabled edges of the pipeline. A pipeline register that slips makes a result appear one slot early or late, and the result lands on its neighbour's slot. A burst counter or order fault sends a beat to the wrong address. That error shows up on the first beat after the start, or on the fifth beat in the wrap case. A write that samples its data or lanes at the wrong edge stays hidden until the address is read back. For that reason every write pattern is followed by a read of the same address. A stall that leaks is caught in the stalled cycle itself, because the output register or the slot of the later result moves.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          burst_cont,
  input  logic          is_read,
  input  logic          ilv_order,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    lane_en_n,
  input  logic [31:0]   wdata,
  input  logic          out_en_n,
  output logic [31:0]   rdata,
  output logic          rvalid,
  output logic          bus_drive
);
  localparam int DEPTH = 1 << AW;
  localparam int NB = 4;

  logic [31:0] mem [DEPTH];

  logic          act, bwr;
  logic [1:0]    bcnt;
  logic [AW-1:0] bstart;
  logic          p1_v, p1_wr, p2_v, p2_wr;
  logic [AW-1:0] p1_a, p2_a;
  logic [NB-1:0] p1_be, p2_be;

  wire sel   = ~sel_a_n & sel_b & ~sel_c_n;
  wire cont  = sel & burst_cont & act;
  wire issue = sel & (~burst_cont | act);
  wire [1:0]    cnt_n = cont ? bcnt + 2'd1 : 2'd0;
  wire [AW-1:0] start = cont ? bstart : addr;
  wire [1:0]    lo    = ilv_order ? (start[1:0] ^ cnt_n) : (start[1:0] + cnt_n);
  wire [AW-1:0] op_a  = {start[AW-1:2], lo};
  wire          op_wr = cont ? bwr : ~is_read;

  assign bus_drive = rvalid & ~out_en_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; bwr <= 1'b0; bcnt <= '0; bstart <= '0;
      p1_v <= 1'b0; p1_wr <= 1'b0; p1_a <= '0; p1_be <= '1;
      p2_v <= 1'b0; p2_wr <= 1'b0; p2_a <= '0; p2_be <= '1;
      rvalid <= 1'b0; rdata <= '0;
    end else if (!hold) begin
      act <= issue;
      if (issue) begin
        bstart <= start;
        bcnt   <= cnt_n;
        bwr    <= op_wr;
      end
      p1_v <= issue; p1_wr <= op_wr; p1_a <= op_a; p1_be <= lane_en_n;
      p2_v <= p1_v;  p2_wr <= p1_wr; p2_a <= p1_a; p2_be <= p1_be;
      rvalid <= p2_v & ~p2_wr;
      if (p2_v && !p2_wr) rdata <= mem[p2_a];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !hold && p2_v && p2_wr)
      for (int i = 0; i < NB; i++)
        if (!p2_be[i]) mem[p2_a][8*i +: 8] <= wdata[8*i +: 8];
  end

  assert_stall_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rdata) && $stable(rvalid));
  assert_stall_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(bcnt) && $stable(act) && $stable(p1_v) && $stable(p2_v));
  assert_new_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && sel && !burst_cont) |=> (bcnt == 2'd0) && act);
  assert_count_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && sel && burst_cont && act) |=> bcnt == $past(bcnt) + 2'd1);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !sel) |=> !act && !p1_v);
  assert_orphan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && burst_cont && !act) |=> !p1_v);
endmodule

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;
  logic clk = 0, rst_n = 0, hold = 0, sel_a_n = 1, sel_b = 0, sel_c_n = 1;
  logic burst_cont = 0, is_read = 0, ilv_order = 0, out_en_n = 0;
  logic [5:0] addr = '0;
  logic [3:0] lane_en_n = '1;
  logic [31:0] wdata = '0, rdata;
  logic rvalid, bus_drive;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  zbt_sram #(.AW(6)) u0 (.clk, .rst_n, .hold, .sel_a_n, .sel_b, .sel_c_n, .burst_cont,
    .is_read, .ilv_order, .addr, .lane_en_n, .wdata, .out_en_n, .rdata, .rvalid, .bus_drive);

  typedef struct packed {
    logic h; logic [2:0] s; logic c; logic r; logic [5:0] a; logic [31:0] d;
    logic ev; logic [31:0] ed;
  } vec_t;

  localparam logic [31:0] A5 = 32'h1111_0005, A6 = 32'h2222_0006, A7 = 32'h3333_0007, A9 = 32'h4444_0009;
  localparam vec_t TBL [14] = '{
    '{1'b0, 3'b010, 1'b0, 1'b0, 6'd5, 32'h0, 1'b0, 32'h0},
    '{1'b0, 3'b010, 1'b0, 1'b0, 6'd6, 32'h0, 1'b0, 32'h0},
    '{1'b0, 3'b010, 1'b0, 1'b1, 6'd5, A5,    1'b0, 32'h0},
    '{1'b0, 3'b010, 1'b0, 1'b1, 6'd6, A6,    1'b0, 32'h0},
    '{1'b0, 3'b010, 1'b0, 1'b0, 6'd7, 32'h0, 1'b1, A5},
    '{1'b0, 3'b110, 1'b0, 1'b0, 6'd0, 32'h0, 1'b1, A6},
    '{1'b0, 3'b010, 1'b0, 1'b1, 6'd7, A7,    1'b0, 32'h0},
    '{1'b0, 3'b110, 1'b0, 1'b0, 6'd0, 32'h0, 1'b0, 32'h0},
    '{1'b0, 3'b110, 1'b0, 1'b0, 6'd0, 32'h0, 1'b1, A7},
    '{1'b0, 3'b010, 1'b0, 1'b0, 6'd9, 32'h0, 1'b0, 32'h0},
    '{1'b0, 3'b010, 1'b0, 1'b1, 6'd9, 32'h0, 1'b0, 32'h0},
    '{1'b0, 3'b110, 1'b0, 1'b0, 6'd0, A9,    1'b0, 32'h0},
    '{1'b0, 3'b110, 1'b0, 1'b0, 6'd0, 32'h0, 1'b1, A9},
    '{1'b0, 3'b110, 1'b0, 1'b0, 6'd0, 32'h0, 1'b0, 32'h0}
  };

  task automatic cyc(input logic h, input logic [2:0] s, input logic c, input logic r,
                     input logic m, input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    {hold, sel_a_n, sel_b, sel_c_n, burst_cont, is_read, ilv_order} = {h, s, c, r, m};
    addr = a; lane_en_n = be; wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic nop(input logic [31:0] d = 32'h0);
    cyc(1'b0, 3'b111, 1'b0, 1'b0, 1'b0, 6'd0, 4'hF, d);
  endtask

  task automatic chk(input string tag, input logic ev, input logic [31:0] ed);
    n_chk++;
    if (rvalid !== ev || (ev && rdata !== ed)) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b data=%h, want valid=%0b data=%h", tag, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic wr_one(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, a, be, 32'h0);
    nop();
    nop(d);
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    cyc(1'b0, 3'b010, 1'b0, 1'b1, 1'b0, a, 4'hF, 32'h0);
    nop();
    nop();
    chk(tag, 1'b1, exp);
  endtask

  task automatic burst_rd(input string tag, input logic m, input logic [5:0] a,
                          input int beats, input logic [5:0] exp_a [5]);
    logic [31:0] exp [5];
    for (int i = 0; i < 5; i++) exp[i] = 32'hB000_0000 | 32'(exp_a[i]);
    for (int i = 0; i < beats + 2; i++) begin
      if (i == 0) cyc(1'b0, 3'b010, 1'b0, 1'b1, m, a, 4'hF, 32'h0);
      else if (i < beats) cyc(1'b0, 3'b010, 1'b1, 1'b0, m, 6'd0, 4'hF, 32'h0);
      else nop();
      if (i >= 2) chk(tag, 1'b1, exp[i-2]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] ord [5];
    repeat (3) nop();
    chk("R1 reset", 1'b0, 32'h0);
    n_chk++;
    if (bus_drive !== 1'b0) begin n_bad++; $display("FAIL R1 drive: got %b want 0", bus_drive); end
    rst_n = 1;
    nop();

    // R3 R5: table of mixed traffic
    for (int i = 0; i < 14; i++) begin
      cyc(TBL[i].h, TBL[i].s, TBL[i].c, TBL[i].r, 1'b0, TBL[i].a, 4'h0, TBL[i].d);
      chk($sformatf("R3/R5 vector %0d", i), TBL[i].ev, TBL[i].ed);
    end

    // R4 byte lanes
    wr_one(6'd20, 4'b0000, 32'hAABB_CCDD);
    wr_one(6'd20, 4'b1010, 32'h1122_3344);
    rd_check("R4 lane merge", 6'd20, 32'hAA22_CC44);

    // R9 driver enable
    out_en_n = 1; #1;
    n_chk++;
    if (bus_drive !== 1'b0) begin n_bad++; $display("FAIL R9 off: got %b want 0", bus_drive); end
    out_en_n = 0; #1;
    n_chk++;
    if (bus_drive !== 1'b1) begin n_bad++; $display("FAIL R9 on: got %b want 1", bus_drive); end

    // R6 R7 R11 bursts
    for (int k = 12; k < 16; k++) wr_one(6'(k), 4'h0, 32'hB000_0000 | 32'(k));
    ord = '{6'd13, 6'd14, 6'd15, 6'd12, 6'd13};
    burst_rd("R6/R11 linear wrap", 1'b0, 6'd13, 5, ord);
    ord = '{6'd13, 6'd12, 6'd15, 6'd14, 6'd0};
    burst_rd("R7 interleaved", 1'b1, 6'd13, 4, ord);
    cyc(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 6'd12, 4'h0, 32'h0);
    cyc(1'b0, 3'b010, 1'b1, 1'b1, 1'b0, 6'd0, 4'h0, 32'h0);
    cyc(1'b0, 3'b010, 1'b1, 1'b1, 1'b0, 6'd0, 4'h0, 32'hE000_0000);
    cyc(1'b0, 3'b010, 1'b1, 1'b1, 1'b0, 6'd0, 4'h0, 32'hE000_0001);
    nop(32'hE000_0002);
    nop(32'hE000_0003);
    rd_check("R6 burst write 12", 6'd12, 32'hE000_0000);
    rd_check("R6 burst write 13", 6'd13, 32'hE000_0001);
    rd_check("R6 burst write 15", 6'd15, 32'hE000_0003);

    // R10 orphan continue
    nop();
    cyc(1'b0, 3'b010, 1'b1, 1'b1, 1'b0, 6'd13, 4'hF, 32'h0);
    nop();
    nop();
    chk("R10 orphan continue", 1'b0, 32'h0);

    // R8 stalls
    wr_one(6'd33, 4'h0, 32'h5A5A_0033);
    cyc(1'b0, 3'b010, 1'b0, 1'b1, 1'b0, 6'd33, 4'hF, 32'h0);
    repeat (3) cyc(1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 6'd40, 4'h0, 32'hDEAD_BEEF);
    chk("R8 stalled read not out", 1'b0, 32'h0);
    nop();
    nop();
    chk("R8 read after stall", 1'b1, 32'h5A5A_0033);
    repeat (2) cyc(1'b1, 3'b010, 1'b0, 1'b1, 1'b0, 6'd20, 4'hF, 32'h0);
    chk("R8 output held", 1'b1, 32'h5A5A_0033);
    cyc(1'b0, 3'b010, 1'b0, 1'b0, 1'b0, 6'd34, 4'h0, 32'h0);
    nop();
    cyc(1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 6'd0, 4'hF, 32'hBAD0_BAD0);
    nop(32'h600D_0034);
    rd_check("R8 write data after stall", 6'd34, 32'h600D_0034);

    // R2 select combinations
    wr_one(6'd40, 4'h0, 32'h1234_5678);
    foreach (TBL[i]) if (i < 7) begin
      logic [2:0] s;
      s = (i == 0) ? 3'b000 : (i == 1) ? 3'b011 : (i == 2) ? 3'b110 : (i == 3) ? 3'b111 :
          (i == 4) ? 3'b100 : (i == 5) ? 3'b001 : 3'b101;
      cyc(1'b0, s, 1'b0, 1'b0, 1'b0, 6'd40, 4'h0, 32'h0);
      nop();
      nop(32'hFFFF_FFFF);
    end
    cyc(1'b0, 3'b011, 1'b0, 1'b1, 1'b0, 6'd40, 4'hF, 32'h0);
    nop();
    nop();
    chk("R2 unselected read", 1'b0, 32'h0);
    rd_check("R2 unselected writes ignored", 6'd40, 32'h1234_5678);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule